// File: doc/BRIEF.md
# Write Protection Status Controller

This block guards every program operation of a 512-byte serial non-volatile memory. It keeps three pieces of state: a write-enable latch, two retained block-protect bits that select how much of the upper address space is locked, and the ready/busy condition of the programming timer. Decoded command strobes from the serial front end drive it, along with the target address and the write-protect pin. For each array write or status write it decides whether the operation may go ahead.

An accepted request is armed and waits for the end of the frame (chip-select deasserted). It then issues a one-cycle start pulse to the programming timer, tagged with its kind. The block follows the timer's busy signal until the cycle finishes. At that point it clears the write-enable latch and, for a status write, loads the new block-protect bits. A rejected request leaves all state as it was and starts nothing.

The block also builds the byte returned on a status read. All of its pins are plain level or strobe signals, because nothing streams through it. Commands arrive as single-cycle strobes and results leave as a level or a single pulse, so there is no back-pressure anywhere.

Top module: `wp_status_ctrl`

## Requirements
- R1: When idle, `status_o` is formatted as follows: bit 0 is the busy flag (1 = programming, 0 = ready), bit 1 is the write-enable latch, bit 2 is the low block-protect bit, bit 3 is the high block-protect bit, and bits 7..4 read 0.
- R2: From the cycle after `prog_start_o` until the timer's busy signal has dropped, `status_o` reads 8'hFF.
- R3: A set-enable strobe sets the latch only while `wp_allow_i` is 1. A clear-enable strobe clears it. Whenever `wp_allow_i` is 0, the latch is cleared on the next clock.
- R4: After reset the latch reads 0 and the block-protect bits hold the parameter `BP_RESET`.
- R5: When an accepted programming cycle ends, the latch is cleared.
- R6: The protect level {high,low} locks addresses as follows: 0 locks none, 1 locks the top quarter (0x180..0x1FF), 2 locks the top half (0x100..0x1FF), and 3 locks all addresses.
- R7: An array write is accepted only if `wp_allow_i` is 1, the latch is set and the address is unlocked. When accepted, `prog_start_o` pulses for one cycle, the cycle after `frame_end_i`, with `prog_kind_o` = 0.
- R8: A status write is accepted only if `wp_allow_i` is 1 and the latch is set; its acceptance does not depend on the address range. It starts with `prog_kind_o` = 1. When the cycle ends, the block-protect bits take bits 3 (high) and 2 (low) of `sr_data_i` and ignore the other bits.
- R9: A rejected write gives no start pulse and changes no state. While programming, the set-enable, clear-enable and write strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_allow_i | input | 1 | Write-protect pin; 1 allows programming |
| cmd_wen_set_i | input | 1 | Set-enable command strobe |
| cmd_wen_clr_i | input | 1 | Clear-enable command strobe |
| cmd_arr_wr_i | input | 1 | Array write command strobe |
| cmd_sr_wr_i | input | 1 | Status write command strobe |
| addr_i | input | ADDR_W | Target byte address of an array write |
| sr_data_i | input | 8 | Data byte of a status write |
| frame_end_i | input | 1 | Chip-select deasserted strobe |
| prog_busy_i | input | 1 | Busy signal from the programming timer |
| prog_start_o | output | 1 | One-cycle start pulse to the timer |
| prog_kind_o | output | 1 | 0 = array job, 1 = status job |
| status_o | output | 8 | Status byte for a status read |

## Verification
The bench builds the block with `ADDR_W` = 9 and `BP_RESET` = 2'b10. With those values the part comes out of reset with the top half locked. A write at 0x150 is therefore rejected before any status write has run, and the reset value of the protect bits can be seen directly in the status byte. Status writes then step the level through 1, 3 and 0, which exercises every range boundary (0x17F/0x180, 0x000, 0x1FF). A small timer model holds the busy signal for six cycles, which gives room to read the all-ones byte and to issue strobes that must be ignored during programming.

// File: rtl/wpsc_pkg.sv
package wpsc_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ARMED  = 2'd1,
    SEQ_LAUNCH = 2'd2,
    SEQ_RUN    = 2'd3
  } seq_state_e;

  typedef enum logic {
    JOB_ARRAY  = 1'b0,
    JOB_STATUS = 1'b1
  } job_kind_e;

  localparam int BP_W      = 2;
  localparam int STAT_W    = 8;
  localparam int STAT_RDY  = 0;
  localparam int STAT_WEN  = 1;
  localparam int STAT_BPLO = 2;
  localparam int STAT_BPHI = 3;
endpackage

// File: rtl/wpsc_range_guard.sv
module wpsc_range_guard #(
  parameter int ADDR_W = 9
) (
  input  logic [1:0]        level_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              locked_o
);
  localparam int TOP = ADDR_W - 1;

  logic top_half;
  logic top_quarter;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign top_half    = addr_i[TOP];
      assign top_quarter = addr_i[TOP] & addr_i[TOP-1];
    end else begin : g_narrow
      assign top_half    = addr_i[TOP];
      assign top_quarter = addr_i[TOP];
    end
  endgenerate

  always_comb begin
    unique case (level_i)
      2'd0:    locked_o = 1'b0;
      2'd1:    locked_o = top_quarter;
      2'd2:    locked_o = top_half;
      default: locked_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wpsc_enable_latch.sv
module wpsc_enable_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_allow_i,
  input  logic set_req_i,
  input  logic clr_req_i,
  input  logic auto_clr_i,
  output logic wen_o
);
  logic wen_q;
  logic drop;

  assign drop = !wp_allow_i || clr_req_i || auto_clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q <= 1'b0;
    end else if (drop) begin
      wen_q <= 1'b0;
    end else if (set_req_i) begin
      wen_q <= 1'b1;
    end
  end

  assign wen_o = wen_q;
endmodule

// File: rtl/wpsc_job_seq.sv
module wpsc_job_seq
  import wpsc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arr_req_i,
  input  logic            sr_req_i,
  input  logic [BP_W-1:0] bp_data_i,
  input  logic            wp_allow_i,
  input  logic            wen_i,
  input  logic            locked_i,
  input  logic            frame_end_i,
  input  logic            prog_busy_i,
  output logic            prog_start_o,
  output job_kind_e       kind_o,
  output logic            in_prog_o,
  output logic            done_o,
  output logic            bp_load_o,
  output logic [BP_W-1:0] bp_next_o
);
  seq_state_e      state_q;
  job_kind_e       kind_q;
  logic            start_q;
  logic [BP_W-1:0] bp_pend_q;
  logic            may_prog;
  logic            arr_ok;
  logic            sr_ok;

  assign may_prog = wp_allow_i && wen_i && !prog_busy_i;
  assign arr_ok   = arr_req_i && may_prog && !locked_i;
  assign sr_ok    = sr_req_i && may_prog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_IDLE;
      kind_q    <= JOB_ARRAY;
      start_q   <= 1'b0;
      bp_pend_q <= '0;
    end else begin
      start_q <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (arr_ok) begin
            state_q <= SEQ_ARMED;
            kind_q  <= JOB_ARRAY;
          end else if (sr_ok) begin
            state_q   <= SEQ_ARMED;
            kind_q    <= JOB_STATUS;
            bp_pend_q <= bp_data_i;
          end
        end
        SEQ_ARMED: begin
          if (frame_end_i) begin
            state_q <= SEQ_LAUNCH;
            start_q <= 1'b1;
          end
        end
        SEQ_LAUNCH: begin
          if (prog_busy_i) state_q <= SEQ_RUN;
        end
        default: begin
          if (!prog_busy_i) state_q <= SEQ_IDLE;
        end
      endcase
    end
  end

  assign prog_start_o = start_q;
  assign kind_o       = kind_q;
  assign in_prog_o    = (state_q == SEQ_LAUNCH) || (state_q == SEQ_RUN);
  assign done_o       = (state_q == SEQ_RUN) && !prog_busy_i;
  assign bp_load_o    = done_o && (kind_q == JOB_STATUS);
  assign bp_next_o    = bp_pend_q;
endmodule

// File: rtl/wpsc_status_fmt.sv
module wpsc_status_fmt
  import wpsc_pkg::*;
(
  input  logic              busy_i,
  input  logic              wen_i,
  input  logic [BP_W-1:0]   bp_i,
  output logic [STAT_W-1:0] status_o
);
  always_comb begin
    status_o = '0;
    if (busy_i) begin
      status_o = '1;
    end else begin
      status_o[STAT_WEN]  = wen_i;
      status_o[STAT_BPLO] = bp_i[0];
      status_o[STAT_BPHI] = bp_i[1];
    end
  end
endmodule

// File: rtl/wp_status_ctrl.sv
module wp_status_ctrl
  import wpsc_pkg::*;
#(
  parameter int              ADDR_W   = 9,
  parameter logic [BP_W-1:0] BP_RESET = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_allow_i,
  input  logic              cmd_wen_set_i,
  input  logic              cmd_wen_clr_i,
  input  logic              cmd_arr_wr_i,
  input  logic              cmd_sr_wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [STAT_W-1:0] sr_data_i,
  input  logic              frame_end_i,
  input  logic              prog_busy_i,
  output logic              prog_start_o,
  output logic              prog_kind_o,
  output logic [STAT_W-1:0] status_o
);
  logic            wen_q;
  logic            locked;
  logic            in_prog;
  logic            busy_any;
  logic            cycle_done;
  logic            bp_load;
  logic [BP_W-1:0] bp_next;
  logic [BP_W-1:0] bp_q;
  job_kind_e       kind;
  logic            unused_sr_bits;

  assign busy_any       = in_prog || prog_busy_i;
  assign unused_sr_bits = ^{sr_data_i[7:4], sr_data_i[1:0]};

  wpsc_range_guard #(.ADDR_W(ADDR_W)) u_guard (
    .level_i  (bp_q),
    .addr_i   (addr_i),
    .locked_o (locked)
  );

  wpsc_enable_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .wp_allow_i (wp_allow_i),
    .set_req_i  (cmd_wen_set_i && !busy_any),
    .clr_req_i  (cmd_wen_clr_i && !busy_any),
    .auto_clr_i (cycle_done),
    .wen_o      (wen_q)
  );

  wpsc_job_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .arr_req_i    (cmd_arr_wr_i && !in_prog),
    .sr_req_i     (cmd_sr_wr_i && !in_prog),
    .bp_data_i    (sr_data_i[STAT_BPHI:STAT_BPLO]),
    .wp_allow_i   (wp_allow_i),
    .wen_i        (wen_q),
    .locked_i     (locked),
    .frame_end_i  (frame_end_i),
    .prog_busy_i  (prog_busy_i),
    .prog_start_o (prog_start_o),
    .kind_o       (kind),
    .in_prog_o    (in_prog),
    .done_o       (cycle_done),
    .bp_load_o    (bp_load),
    .bp_next_o    (bp_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_q <= BP_RESET;
    end else if (bp_load) begin
      bp_q <= bp_next;
    end
  end

  assign prog_kind_o = (kind == JOB_STATUS);

  wpsc_status_fmt u_fmt (
    .busy_i   (busy_any),
    .wen_i    (wen_q),
    .bp_i     (bp_q),
    .status_o (status_o)
  );
endmodule

// File: rtl/wpsc_checker.sv
module wpsc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_allow_i,
  input logic       frame_end_i,
  input logic       prog_start_o,
  input logic [7:0] status_o,
  input logic       wen_q
);
  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start_o |=> (status_o == 8'hFF));

  assert_wp_low_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_allow_i |=> !wen_q);

  assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[0]) |-> !wen_q);

  assert_start_after_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start_o |-> ($past(frame_end_i) && wen_q));

  assert_start_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start_o |=> !prog_start_o);

  assert_no_start_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start_o |-> !$past(status_o[0]));
endmodule

bind wp_status_ctrl wpsc_checker chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .wp_allow_i   (wp_allow_i),
  .frame_end_i  (frame_end_i),
  .prog_start_o (prog_start_o),
  .status_o     (status_o),
  .wen_q        (wen_q)
);

// File: tb/wp_status_ctrl_tb_top.sv
module wp_status_ctrl_tb_top;
  localparam int         AW  = 9;
  localparam logic [1:0] BPR = 2'b10;

  localparam int C_SET = 0, C_CLR = 1, C_ARR = 2, C_SR = 3, C_END = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          wp = 1'b0;
  logic          wset = 1'b0, wclr = 1'b0, arr = 1'b0, srw = 1'b0, fend = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    sdat = '0;
  logic          busy;
  logic          start;
  logic          kind;
  logic [7:0]    stat;
  int            busy_left = 0;

  wp_status_ctrl #(.ADDR_W(AW), .BP_RESET(BPR)) dut_i (
    .clk(clk), .rst_n(rst_n), .wp_allow_i(wp),
    .cmd_wen_set_i(wset), .cmd_wen_clr_i(wclr),
    .cmd_arr_wr_i(arr), .cmd_sr_wr_i(srw),
    .addr_i(addr), .sr_data_i(sdat), .frame_end_i(fend),
    .prog_busy_i(busy), .prog_start_o(start), .prog_kind_o(kind),
    .status_o(stat)
  );

  // timer model: six busy cycles after each start pulse
  always @(posedge clk) begin
    if (!rst_n) busy_left <= 0;
    else if (start) busy_left <= 6;
    else if (busy_left > 0) busy_left <= busy_left - 1;
  end
  assign busy = (busy_left != 0);

  typedef struct {
    string      tag;
    logic [7:0] stat;
    int         starts;
    int         kind;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0, n_bad = 0, n_starts = 0, last_kind = -1;
  bit   finished = 1'b0;

  // monitor: count start pulses, pop and compare expectations
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && start) begin
      n_starts++;
      last_kind = int'(kind);
    end
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      n_vec++;
      if (stat !== e.stat || n_starts != e.starts ||
          (e.kind >= 0 && last_kind != e.kind)) begin
        n_bad++;
        $display("FAIL %s: status=%h starts=%0d kind=%0d expected status=%h starts=%0d kind=%0d",
                 e.tag, stat, n_starts, last_kind, e.stat, e.starts, e.kind);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cmd(input int which, input logic [AW-1:0] a = '0, input logic [7:0] d = '0);
    @(posedge clk); #1;
    addr = a;
    sdat = d;
    case (which)
      C_SET:   wset = 1'b1;
      C_CLR:   wclr = 1'b1;
      C_ARR:   arr  = 1'b1;
      C_SR:    srw  = 1'b1;
      default: fend = 1'b1;
    endcase
    @(posedge clk); #1;
    wset = 1'b0; wclr = 1'b0; arr = 1'b0; srw = 1'b0; fend = 1'b0;
  endtask

  task automatic expect_now(input string tag, input logic [7:0] s, input int st, input int k);
    exp_t e;
    e.tag = tag; e.stat = s; e.starts = st; e.kind = k;
    exp_q.push_back(e);
    tick(1);
  endtask

  task automatic arr_frame(input logic [AW-1:0] a);
    cmd(C_ARR, a);
    cmd(C_END);
  endtask

  task automatic sr_frame(input logic [7:0] d);
    cmd(C_SR, '0, d);
    cmd(C_END);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    expect_now("R4 R1 reset status, protect bits from parameter", 8'h08, 0, -1);

    cmd(C_SET);
    expect_now("R3 set-enable ignored with pin low", 8'h08, 0, -1);

    wp = 1'b1; tick(1);
    cmd(C_SET);
    expect_now("R3 R1 set-enable with pin high", 8'h0A, 0, -1);

    cmd(C_CLR);
    expect_now("R3 clear-enable", 8'h08, 0, -1);

    cmd(C_SET);
    wp = 1'b0; tick(2);
    expect_now("R3 pin low clears latch", 8'h08, 0, -1);

    wp = 1'b1; tick(1);
    cmd(C_SET);
    arr_frame(9'h150);
    tick(10);
    expect_now("R6 R9 level 2 rejects 0x150, no start", 8'h0A, 0, -1);

    arr_frame(9'h0FF);
    tick(2);
    expect_now("R2 all ones while programming", 8'hFF, 1, 0);
    tick(20);
    expect_now("R5 R7 array write done, latch cleared", 8'h08, 1, 0);

    arr_frame(9'h0FF);
    tick(10);
    expect_now("R7 write without latch rejected", 8'h08, 1, -1);

    cmd(C_SET);
    sr_frame(8'hF4);
    tick(20);
    expect_now("R8 R5 status write sets level 1", 8'h04, 2, 1);

    cmd(C_SET);
    arr_frame(9'h180);
    tick(10);
    expect_now("R6 level 1 rejects 0x180", 8'h06, 2, -1);

    arr_frame(9'h17F);
    tick(20);
    expect_now("R6 R7 level 1 accepts 0x17F", 8'h04, 3, 0);

    cmd(C_SET);
    sr_frame(8'h0C);
    tick(20);
    expect_now("R8 status write sets level 3", 8'h0C, 4, 1);

    cmd(C_SET);
    arr_frame(9'h000);
    tick(10);
    expect_now("R6 level 3 rejects 0x000", 8'h0E, 4, -1);

    sr_frame(8'h00);
    tick(20);
    expect_now("R8 status write not range gated, level 0", 8'h00, 5, 1);

    cmd(C_SET);
    arr_frame(9'h1FF);
    tick(1);
    cmd(C_SET);
    tick(20);
    expect_now("R9 set-enable ignored while programming", 8'h00, 6, 0);

    sr_frame(8'h0C);
    tick(10);
    expect_now("R9 R8 status write without latch rejected", 8'h00, 6, -1);

    cmd(C_SET);
    wp = 1'b0;
    sr_frame(8'h0C);
    tick(10);
    expect_now("R8 status write with pin low rejected", 8'h00, 6, -1);

    wp = 1'b1;
    cmd(C_END);
    tick(10);
    expect_now("R9 frame end with nothing armed", 8'h00, 6, -1);

    tick(2);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule